// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block turns single host register writes into NAND bus activity. The host loads a command byte and an address byte into holding registers. It then writes a trigger word with exactly one operation bit set. The sequencer drives the flash control pins with fixed pulse widths and moves bytes between the flash data pins and an external page buffer. When the operation ends it sets a completion flag, which the host polls.

Ready/busy is handled inside the block. Every read-type operation holds off its first read strobe until the synchronised ready/busy input shows ready, so software never samples that pin itself.

Three further host controls are provided:
- a chip-enable bit together with a small chip-select field, which together pick one active-low chip enable;
- a pages-per-block code, decoded to a page count for neighbouring logic;
- a self-clearing controller reset that aborts any operation in progress.

Top module: `nand_seq`

## Requirements
- R1: Writing register select 4 (trigger) with only bit 0 set produces one write-strobe pulse (nand_we_n low for 2 clocks, then high for 2 clocks). During that pulse nand_cle is high, nand_ale is low and nand_dq_o carries the byte last written to select 0 (command byte).
- R2: A trigger with only bit 1 set produces one write-strobe pulse with nand_ale high, nand_cle low, and nand_dq_o equal to the byte at select 1 (address byte).
- R3: A trigger with only bit 2 set (program) produces PAGE_BYTES write-strobe pulses with nand_cle and nand_ale low. Pulse i drives buf_rdata taken at buf_idx = i, for i counting up from 0.
- R4: A trigger with only bit 3 set (page read) produces no read strobe until nand_rb_n is high. It then produces PAGE_BYTES read-strobe pulses, each with nand_re_n low for 2 clocks. Each pulse stores the nand_dq_i byte into the buffer at buf_idx = 0, 1, 2, … through buf_we.
- R5: A trigger with only bit 4 set (ID read) transfers ID_BYTES bytes into buffer indices from 0. A trigger with only bit 5 set (status read) transfers exactly one byte into index 0.
- R6: Bit 15 of the trigger register reads 1 once an operation has finished. It reads 0 from the cycle after a trigger is accepted until that operation ends.
- R7: A trigger write is ignored when an operation is in progress, when a controller reset is pending, or when bits 5:0 are not exactly one-hot. An ignored trigger causes no pin activity and leaves the completion flag unchanged.
- R8: Starting a data operation (trigger bit 2, 3, 4 or 5) clears the buffer-select field, bits 2:0 of select 2. The chip-select field at bits 6:5 of the same register is kept.
- R9: When bit 7 of select 3 (configuration) is 1, nand_ce_n[k] is low only for k equal to the chip-select field (select 2, bits 6:5). When that bit is 0, all chip enables are high.
- R10: Writing 1 to configuration bit 6 makes that bit read 1 for RST_CYCLES clocks, after which it clears itself. The reset aborts any operation: strobes return high and the trigger register reads 0. The configuration fields in bits 10:9 and 7 keep the values written with it.
- R11: Configuration bits 10:9 hold a code 0 to 3 that reads back unchanged. The code drives pages_per_block to 32, 64, 128 or 256.
- R12: After rst_n is released, nand_we_n and nand_re_n are high, nand_cle, nand_ale and nand_dq_oe are low, all chip enables are high, every register reads 0, and pages_per_block is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Register select: 0 command, 1 address, 2 buffer/chip select, 3 configuration, 4 trigger |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data of the selected register |
| buf_idx | output | $clog2(PAGE_BYTES) | Page buffer byte index |
| buf_rdata | input | 8 | Buffer byte at buf_idx, used by program |
| buf_wdata | output | 8 | Byte to store into the buffer |
| buf_we | output | 1 | Buffer store strobe |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | NUM_CS | Chip enables, active low |
| nand_dq_o | output | 8 | Data driven towards the flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_o |
| nand_dq_i | input | 8 | Data from the flash |
| nand_rb_n | input | 1 | Flash ready (high) / busy (low) |
| pages_per_block | output | 9 | Decoded pages-per-block count |

## Verification
The bound checker watches several properties on every cycle:
- CLE and ALE are never high together.
- The write and read strobes are never low together.
- At most one chip enable is low.
- Data is held steady through each write-strobe low phase.
- Every read-strobe low phase lasts the set width.
- Buffer stores occur only inside a read strobe.
- The data output enable never overlaps a read strobe.
- The completion flag rises only at the end of a busy operation.

Only the directed scenarios can show the rest. These are the byte values and their ordering into and out of the buffer, the hold-off on a busy flash, the rejection of late or malformed triggers, the clearing of the buffer-select field, and the recovery of state after a controller reset.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_RBWAIT, ST_LO, ST_HI} seq_state_t;

   localparam int OP_W     = 6;
   localparam int OPB_CMD  = 0;
   localparam int OPB_ADR  = 1;
   localparam int OPB_PROG = 2;
   localparam int OPB_PAGE = 3;
   localparam int OPB_ID   = 4;
   localparam int OPB_STAT = 5;
   localparam int DONE_BIT = 15;

   localparam logic [2:0] SEL_CMD  = 3'd0;
   localparam logic [2:0] SEL_ADR  = 3'd1;
   localparam logic [2:0] SEL_BUF  = 3'd2;
   localparam logic [2:0] SEL_CFG  = 3'd3;
   localparam logic [2:0] SEL_TRIG = 3'd4;
endpackage

// File: rtl/nand_seq_sync.sv
module nand_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else if (STAGES == 1) sh <= d;
            else sh <= {sh[STAGES-2:0], d};
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
   import nand_seq_pkg::*;
#(
   parameter int NUM_CS     = 4,
   parameter int RST_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_sel,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   input  logic              eng_busy,
   input  logic [OP_W-1:0]   eng_op,
   input  logic              eng_done,
   output logic              start,
   output logic [OP_W-1:0]   start_op,
   output logic [7:0]        cmd_byte,
   output logic [7:0]        adr_byte,
   output logic              ctl_rst,
   output logic              done_flag,
   output logic [NUM_CS-1:0] ce_n,
   output logic [8:0]        pages
);
   localparam int RC_W = $clog2(RST_CYCLES + 1);

   logic [2:0]      rba_q;
   logic [1:0]      cs_q;
   logic            ce_q;
   logic [1:0]      ppb_q;
   logic [RC_W-1:0] rcnt;
   logic            rst_req;

   assign ctl_rst  = (rcnt != '0);
   assign rst_req  = reg_wr && (reg_sel == SEL_CFG) && reg_wdata[6];
   assign start_op = reg_wdata[OP_W-1:0];
   assign start    = reg_wr && (reg_sel == SEL_TRIG) && !eng_busy && !ctl_rst
                     && $onehot(reg_wdata[OP_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_byte  <= '0;
         adr_byte  <= '0;
         rba_q     <= '0;
         cs_q      <= '0;
         ce_q      <= 1'b0;
         ppb_q     <= '0;
         rcnt      <= '0;
         done_flag <= 1'b0;
      end else begin
         if (reg_wr && reg_sel == SEL_CMD) cmd_byte <= reg_wdata[7:0];
         if (reg_wr && reg_sel == SEL_ADR) adr_byte <= reg_wdata[7:0];
         if (reg_wr && reg_sel == SEL_BUF) begin
            rba_q <= reg_wdata[2:0];
            cs_q  <= reg_wdata[6:5];
         end
         if (start && (|reg_wdata[OPB_STAT:OPB_PROG])) rba_q <= '0;
         if (reg_wr && reg_sel == SEL_CFG) begin
            ce_q  <= reg_wdata[7];
            ppb_q <= reg_wdata[10:9];
         end
         if (rst_req) rcnt <= RC_W'(RST_CYCLES);
         else if (ctl_rst) rcnt <= rcnt - 1'b1;
         if (rst_req || ctl_rst || start) done_flag <= 1'b0;
         else if (eng_done) done_flag <= 1'b1;
      end
   end

   always_comb begin
      case (reg_sel)
         SEL_CMD:  reg_rdata = {8'h00, cmd_byte};
         SEL_ADR:  reg_rdata = {8'h00, adr_byte};
         SEL_BUF:  reg_rdata = {9'h000, cs_q, 2'b00, rba_q};
         SEL_CFG:  reg_rdata = {5'h00, ppb_q, 1'b0, ce_q, ctl_rst, 6'h00};
         SEL_TRIG: reg_rdata = {done_flag, 9'h000, eng_op};
         default:  reg_rdata = 16'h0000;
      endcase
   end

   assign pages = 9'd32 << ppb_q;

   for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
      assign ce_n[g] = !(ce_q && (cs_q == 2'(g)));
   end
endmodule

// File: rtl/nand_seq_engine.sv
module nand_seq_engine
   import nand_seq_pkg::*;
#(
   parameter int PAGE_BYTES = 512,
   parameter int ID_BYTES   = 4,
   parameter int T_LOW      = 2,
   parameter int T_HIGH     = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          abort,
   input  logic                          start,
   input  logic [OP_W-1:0]               start_op,
   input  logic [7:0]                    cmd_byte,
   input  logic [7:0]                    adr_byte,
   input  logic                          rb_ready,
   input  logic [7:0]                    buf_rdata,
   input  logic [7:0]                    dq_i,
   output logic [$clog2(PAGE_BYTES)-1:0] buf_idx,
   output logic [7:0]                    buf_wdata,
   output logic                          buf_we,
   output logic                          cle,
   output logic                          ale,
   output logic                          we_n,
   output logic                          re_n,
   output logic [7:0]                    dq_o,
   output logic                          dq_oe,
   output logic                          busy,
   output logic                          done,
   output logic [OP_W-1:0]               op
);
   localparam int IDX_W = $clog2(PAGE_BYTES);
   localparam int CNT_W = $clog2(PAGE_BYTES + 1);
   localparam int TMAX  = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
   localparam int TW    = $clog2(TMAX) + 1;

   seq_state_t       st;
   logic [OP_W-1:0]  op_q;
   logic [CNT_W-1:0] byte_q;
   logic [CNT_W-1:0] nbytes;
   logic [TW-1:0]    tcnt;
   logic             is_rd, is_wr, active, last;

   assign is_rd  = op_q[OPB_PAGE] | op_q[OPB_ID] | op_q[OPB_STAT];
   assign is_wr  = op_q[OPB_CMD] | op_q[OPB_ADR] | op_q[OPB_PROG];
   assign active = (st == ST_LO) || (st == ST_HI);

   always_comb begin
      if (op_q[OPB_PROG] || op_q[OPB_PAGE]) nbytes = CNT_W'(PAGE_BYTES);
      else if (op_q[OPB_ID])                nbytes = CNT_W'(ID_BYTES);
      else                                  nbytes = CNT_W'(1);
   end
   assign last = (byte_q == nbytes - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; op_q <= '0; byte_q <= '0; tcnt <= '0;
      end else if (abort) begin
         st <= ST_IDLE; op_q <= '0; byte_q <= '0; tcnt <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               op_q   <= start_op;
               byte_q <= '0;
               if (start_op[OPB_PAGE] | start_op[OPB_ID] | start_op[OPB_STAT]) st <= ST_RBWAIT;
               else begin st <= ST_LO; tcnt <= TW'(T_LOW - 1); end
            end
            ST_RBWAIT: if (rb_ready) begin st <= ST_LO; tcnt <= TW'(T_LOW - 1); end
            ST_LO: if (tcnt == '0) begin st <= ST_HI; tcnt <= TW'(T_HIGH - 1); end
                   else tcnt <= tcnt - 1'b1;
            ST_HI: if (tcnt != '0) tcnt <= tcnt - 1'b1;
                   else if (last) begin st <= ST_IDLE; op_q <= '0; end
                   else begin
                      byte_q <= byte_q + 1'b1;
                      st     <= ST_LO;
                      tcnt   <= TW'(T_LOW - 1);
                   end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st != ST_IDLE);
   assign op        = op_q;
   assign done      = (st == ST_HI) && (tcnt == '0) && last;
   assign cle       = active && op_q[OPB_CMD];
   assign ale       = active && op_q[OPB_ADR];
   assign we_n      = !((st == ST_LO) && is_wr);
   assign re_n      = !((st == ST_LO) && is_rd);
   assign dq_oe     = active && is_wr;
   assign dq_o      = op_q[OPB_CMD] ? cmd_byte : (op_q[OPB_ADR] ? adr_byte : buf_rdata);
   assign buf_idx   = byte_q[IDX_W-1:0];
   assign buf_wdata = dq_i;
   assign buf_we    = (st == ST_LO) && is_rd && (tcnt == '0);
endmodule

// File: rtl/nand_seq.sv
module nand_seq
   import nand_seq_pkg::*;
#(
   parameter int PAGE_BYTES  = 512,
   parameter int ID_BYTES    = 4,
   parameter int NUM_CS      = 4,
   parameter int T_LOW       = 2,
   parameter int T_HIGH      = 2,
   parameter int RST_CYCLES  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_wr,
   input  logic [2:0]                    reg_sel,
   input  logic [15:0]                   reg_wdata,
   output logic [15:0]                   reg_rdata,
   output logic [$clog2(PAGE_BYTES)-1:0] buf_idx,
   input  logic [7:0]                    buf_rdata,
   output logic [7:0]                    buf_wdata,
   output logic                          buf_we,
   output logic                          nand_cle,
   output logic                          nand_ale,
   output logic                          nand_we_n,
   output logic                          nand_re_n,
   output logic [NUM_CS-1:0]             nand_ce_n,
   output logic [7:0]                    nand_dq_o,
   output logic                          nand_dq_oe,
   input  logic [7:0]                    nand_dq_i,
   input  logic                          nand_rb_n,
   output logic [8:0]                    pages_per_block
);
   if (PAGE_BYTES < 2)        $error("PAGE_BYTES must be at least 2");
   if (ID_BYTES < 1 || ID_BYTES > PAGE_BYTES) $error("ID_BYTES out of range");
   if (NUM_CS < 1 || NUM_CS > 4) $error("NUM_CS must be 1 to 4");
   if (T_LOW < 1 || T_HIGH < 1)  $error("strobe widths must be at least 1");
   if (RST_CYCLES < 1)        $error("RST_CYCLES must be at least 1");
   if (SYNC_STAGES < 0)       $error("SYNC_STAGES must not be negative");

   logic            start_w, eng_busy_w, eng_done_w, ctl_rst_w, done_w, rb_ready_w;
   logic [OP_W-1:0] start_op_w, eng_op_w;
   logic [7:0]      cmd_w, adr_w;

   nand_seq_regs #(.NUM_CS(NUM_CS), .RST_CYCLES(RST_CYCLES)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy_w),
      .eng_op(eng_op_w), .eng_done(eng_done_w), .start(start_w),
      .start_op(start_op_w), .cmd_byte(cmd_w), .adr_byte(adr_w),
      .ctl_rst(ctl_rst_w), .done_flag(done_w), .ce_n(nand_ce_n),
      .pages(pages_per_block));

   nand_seq_sync #(.STAGES(SYNC_STAGES)) u_rbsync (
      .clk(clk), .rst_n(rst_n), .d(nand_rb_n), .q(rb_ready_w));

   nand_seq_engine #(.PAGE_BYTES(PAGE_BYTES), .ID_BYTES(ID_BYTES),
                     .T_LOW(T_LOW), .T_HIGH(T_HIGH)) u_eng (
      .clk(clk), .rst_n(rst_n), .abort(ctl_rst_w), .start(start_w),
      .start_op(start_op_w), .cmd_byte(cmd_w), .adr_byte(adr_w),
      .rb_ready(rb_ready_w), .buf_rdata(buf_rdata), .dq_i(nand_dq_i),
      .buf_idx(buf_idx), .buf_wdata(buf_wdata), .buf_we(buf_we),
      .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
      .dq_o(nand_dq_o), .dq_oe(nand_dq_oe), .busy(eng_busy_w),
      .done(eng_done_w), .op(eng_op_w));
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
   parameter int NUM_CS = 4,
   parameter int T_LOW  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_rst,
   input logic              cle,
   input logic              ale,
   input logic              we_n,
   input logic              re_n,
   input logic [NUM_CS-1:0] ce_n,
   input logic [7:0]        dq_o,
   input logic              dq_oe,
   input logic              buf_we,
   input logic              busy,
   input logic              done_flag
);
   logic [15:0] re_lo_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) re_lo_cnt <= '0;
      else if (ctl_rst || re_n) re_lo_cnt <= '0;
      else re_lo_cnt <= re_lo_cnt + 1'b1;
   end

   a_r1_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));
   a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));
   a_r9_ce_single: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~ce_n) <= 1);
   a_r1_dq_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n && $past(!we_n)) |-> $stable(dq_o));
   a_r4_re_width: assert property (@(posedge clk) disable iff (!rst_n || ctl_rst)
      $rose(re_n) |-> (re_lo_cnt == 16'(T_LOW)));
   a_r4_store_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> !re_n);
   a_r3_oe_not_reading: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> re_n);
   a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> $past(busy));
endmodule

bind nand_seq nand_seq_chk #(.NUM_CS(NUM_CS), .T_LOW(T_LOW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_rst(ctl_rst_w), .cle(nand_cle),
   .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n), .ce_n(nand_ce_n),
   .dq_o(nand_dq_o), .dq_oe(nand_dq_oe), .buf_we(buf_we),
   .busy(eng_busy_w), .done_flag(done_w));

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
   localparam int PB  = 8;
   localparam int IDB = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_sel = 3'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic [2:0]  buf_idx;
   logic [7:0]  buf_rdata, buf_wdata;
   logic        buf_we, cle, ale, we_n, re_n, dq_oe;
   logic [3:0]  ce_n;
   logic [7:0]  dq_o;
   logic [7:0]  dq_i = 8'h00;
   logic        rb_n = 1'b1;
   logic [8:0]  pages;

   int total = 0;
   int fails = 0;

   always #2 clk = ~clk;

   nand_seq #(.PAGE_BYTES(PB), .ID_BYTES(IDB)) u_nand_seq (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_idx(buf_idx),
      .buf_rdata(buf_rdata), .buf_wdata(buf_wdata), .buf_we(buf_we),
      .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
      .nand_ce_n(ce_n), .nand_dq_o(dq_o), .nand_dq_oe(dq_oe),
      .nand_dq_i(dq_i), .nand_rb_n(rb_n), .pages_per_block(pages));

   logic [7:0] mem [PB];
   assign buf_rdata = mem[buf_idx];

   function automatic logic [7:0] flash_byte(input int k);
      return 8'((k * 37) + 11);
   endfunction

   // pin monitor, sampled away from the clock edge
   int         wn = 0, rn = 0, wlow = 0, rlow = 0, wlow_last = 0, rlow_last = 0;
   logic       prev_we = 1'b1, prev_re = 1'b1;
   logic [9:0] wlog [256];
   always @(negedge clk) begin
      if (!we_n && prev_we) begin wlog[wn[7:0]] = {cle, ale, dq_o}; wn++; end
      if (!we_n) wlow++;
      else if (!prev_we) begin wlow_last = wlow; wlow = 0; end
      if (!re_n && prev_re) begin dq_i = flash_byte(rn); rn++; end
      if (!re_n) rlow++;
      else if (!prev_re) begin rlow_last = rlow; rlow = 0; end
      if (buf_we) mem[buf_idx] = buf_wdata;
      prev_we = we_n;
      prev_re = re_n;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [15:0] d);
      reg_sel = s;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_done(input string tag);
      logic [15:0] d;
      int n = 0;
      do begin
         @(negedge clk);
         rd(3'd4, d);
         n++;
      end while (!d[15] && n < 2000);
      chk(tag, d[15], 1'b1);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      chk("R12 we_n", we_n, 1'b1);
      chk("R12 re_n", re_n, 1'b1);
      chk("R12 cle/ale/oe", {cle, ale, dq_oe}, 3'b000);
      chk("R12 ce_n", ce_n, 4'hF);
      for (int s = 0; s < 5; s++) begin
         rd(3'(s), d);
         chk("R12 register zero", d, 16'h0);
      end
      chk("R12 pages", pages, 9'd32);
   endtask

   task automatic t_chip_enable();
      logic [15:0] d;
      wr(3'd2, 16'h0040);
      wr(3'd3, 16'h0480);
      chk("R9 ce select 2", ce_n, 4'b1011);
      chk("R11 pages code 2", pages, 9'd128);
      rd(3'd3, d);
      chk("R11 cfg readback", d, 16'h0480);
      wr(3'd3, 16'h0600);
      chk("R9 ce disabled", ce_n, 4'hF);
      chk("R11 pages code 3", pages, 9'd256);
      wr(3'd3, 16'h0280);
      wr(3'd2, 16'h0000);
      chk("R9 ce select 0", ce_n, 4'b1110);
      chk("R11 pages code 1", pages, 9'd64);
   endtask

   task automatic t_cmd_addr();
      logic [15:0] d;
      int w0;
      wr(3'd0, 16'h0090);
      w0 = wn;
      wr(3'd4, 16'h0001);
      wait_done("R6 done after command");
      chk("R1 one strobe", wn - w0, 1);
      chk("R1 cle latch byte", wlog[w0[7:0]], {2'b10, 8'h90});
      chk("R1 strobe low width", wlow_last, 2);
      wr(3'd1, 16'h003C);
      w0 = wn;
      wr(3'd4, 16'h0002);
      rd(3'd4, d);
      chk("R6 flag cleared by trigger", d[15], 1'b0);
      wait_done("R6 done after address");
      chk("R2 one strobe", wn - w0, 1);
      chk("R2 ale latch byte", wlog[w0[7:0]], {2'b01, 8'h3C});
   endtask

   task automatic t_program();
      logic [15:0] d;
      int w0;
      for (int i = 0; i < PB; i++) mem[i] = 8'(8'h10 + i * 3);
      wr(3'd2, 16'h0025);
      w0 = wn;
      wr(3'd4, 16'h0004);
      wr(3'd4, 16'h0001);
      wait_done("R6 done after program");
      chk("R3 strobe count", wn - w0, PB);
      chk("R7 no command cycle during program", wn - w0, PB);
      for (int i = 0; i < PB; i++)
         chk("R3 program byte", wlog[8'(w0 + i)], {2'b00, 8'(8'h10 + i * 3)});
      rd(3'd2, d);
      chk("R8 buffer select cleared", d, 16'h0020);
      chk("R9 ce follows select 1", ce_n, 4'b1101);
      wr(3'd2, 16'h0000);
   endtask

   task automatic t_not_onehot();
      logic [15:0] d;
      int w0, r0;
      w0 = wn; r0 = rn;
      wr(3'd4, 16'h0003);
      repeat (10) @(negedge clk);
      chk("R7 multi-bit trigger no strobes", (wn - w0) + (rn - r0), 0);
      rd(3'd4, d);
      chk("R7 flag kept", d, 16'h8000);
   endtask

   task automatic t_page_read();
      logic [15:0] d;
      int r0;
      rb_n = 1'b0;
      r0 = rn;
      wr(3'd4, 16'h0008);
      repeat (20) @(negedge clk);
      chk("R4 held off while busy", rn - r0, 0);
      rd(3'd4, d);
      chk("R4 waiting, not done", d, 16'h0008);
      rb_n = 1'b1;
      wait_done("R6 done after page read");
      chk("R4 read strobes", rn - r0, PB);
      for (int i = 0; i < PB; i++)
         chk("R4 stored byte", mem[i], flash_byte(r0 + i));
      chk("R4 read strobe low width", rlow_last, 2);
   endtask

   task automatic t_id_status();
      int r0;
      for (int i = 0; i < PB; i++) mem[i] = 8'hEE;
      r0 = rn;
      wr(3'd4, 16'h0010);
      wait_done("R6 done after ID");
      chk("R5 ID strobes", rn - r0, IDB);
      for (int i = 0; i < IDB; i++)
         chk("R5 ID byte", mem[i], flash_byte(r0 + i));
      chk("R5 ID length bound", mem[IDB], 8'hEE);
      mem[1] = 8'hEE;
      r0 = rn;
      wr(3'd4, 16'h0020);
      wait_done("R6 done after status");
      chk("R5 status strobes", rn - r0, 1);
      chk("R5 status byte", mem[0], flash_byte(r0));
      chk("R5 status single byte", mem[1], 8'hEE);
   endtask

   task automatic t_ctl_reset();
      logic [15:0] d;
      int w0, r1;
      wr(3'd4, 16'h0008);
      repeat (6) @(negedge clk);
      wr(3'd3, 16'h04C0);
      rd(3'd3, d);
      chk("R10 reset bit set", d[6], 1'b1);
      w0 = wn;
      wr(3'd4, 16'h0001);
      repeat (12) @(negedge clk);
      rd(3'd3, d);
      chk("R10 reset bit self-clears", d, 16'h0480);
      rd(3'd4, d);
      chk("R10 trigger register cleared", d, 16'h0000);
      chk("R10 strobes idle", {we_n, re_n}, 2'b11);
      chk("R7 trigger during reset ignored", wn - w0, 0);
      r1 = rn;
      repeat (10) @(negedge clk);
      chk("R10 read aborted", rn - r1, 0);
   endtask

   initial begin
      for (int i = 0; i < PB; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_chip_enable();
      t_cmd_addr();
      t_program();
      t_not_onehot();
      t_page_read();
      t_id_status();
      t_ctl_reset();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(4 * 150000);
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule